// File: doc/BRIEF.md
# GPIO Port Register Bank with Per-Pin Source Selection

This block is one memory-mapped general-purpose I/O port. Software sees three 32-bit registers: an output value register, a direction register and a source-select register. Each pad gets an output enable and an output value. A pin can be driven from the software registers. It can also be handed to a hardware function that supplies its own value and enable through the `hw_data` and `hw_dir` ports.

Parameters set the following:
- the number of pins;
- the reset value of the output value register;
- the reset value of the direction register;
- the reset value of the source selection;
- whether source selection exists at all;
- whether source selection is one shared bit for the whole port or one bit per pin.

Register access uses a single-cycle write strobe. Read data is returned combinationally from the address.

Top module: `gpio_srcsel_port`

## Requirements
- R1: After reset, the output value register holds `DATA_RST` and the direction register holds `DIR_RST`. The source selection holds `SRC_RST`, copied into every bit when there is one bit per pin.
- R2: The output value register is at offset 0x0C. A write takes effect at the clock edge that samples `wr_en`. A read returns the last value written, whatever the direction or the pad state.
- R3: The direction register is at offset 0x10. Bit i set to 1 makes pin i an output and 0 makes it an input. Each bit acts only on its own pin.
- R4: A pin whose source bit is 0 (software) has `pad_oe[i]` equal to its direction bit. Its `pad_out[i]` equals its output value bit when enabled, and 0 otherwise.
- R5: A pin whose source bit is 1 (hardware) takes `pad_oe[i] = hw_dir[i]` and `pad_out[i] = hw_data[i] & hw_dir[i]`.
- R6: With `SHARED_SRC = 0` and `HW_SRC_EN = 1`, the source register at offset 0x14 has one bit per pin, in bits WIDTH-1:0. Each bit can be written on its own and reads back as written.
- R7: With `SHARED_SRC = 1` and `HW_SRC_EN = 1`, the source register is the single bit 0 at offset 0x14. It selects the source for all pins at once, and bits 31:1 read as zero.
- R8: With `HW_SRC_EN = 0`, offset 0x14 reads as zero and ignores writes. Every pin uses software mode.
- R9: Register bits from 31 down to the port width read as zero, and data written to them is dropped.
- R10: A read of any other offset returns zero. A write to any other offset changes no register and no pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hw_data | input | WIDTH | Output values from the hardware source |
| hw_dir | input | WIDTH | Output enables from the hardware source |
| pad_oe | output | WIDTH | Per-pin pad output enable |
| pad_out | output | WIDTH | Per-pin pad output value |

## Verification
The bench builds three 8-pin copies that share one register bus. The first has one source bit per pin. The second has a shared source bit that resets to hardware mode. The third has source selection removed, with a source reset parameter that must not show through. Because the copies see identical writes, a single write to offset 0x14 shows three things side by side: independent per-pin mixing of the two sources, all-pin switching from one bit, and a register that is absent. The same writes also show reserved upper bits being dropped in each of the three layouts.

// File: rtl/gpio_srcsel_pkg.sv
package gpio_srcsel_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h14;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_SRC  = 2'd3
  } reg_sel_e;

  // Map a byte offset to the register it addresses.
  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a, input bit src_present);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == OFS_DATA)                 s = SEL_DATA;
    else if (a == OFS_DIR)             s = SEL_DIR;
    else if (a == OFS_SRC && src_present) s = SEL_SRC;
    return s;
  endfunction

  // Value of one pin: source 1 picks the hardware side.
  function automatic logic [1:0] pick_pin(input logic src_hw,
                                          input logic sw_dir, input logic sw_val,
                                          input logic hw_dir, input logic hw_val);
    logic oe, v;
    oe = src_hw ? hw_dir : sw_dir;
    v  = src_hw ? hw_val : sw_val;
    return {oe, oe & v};
  endfunction

endpackage

// File: rtl/gpio_srcsel_regs.sv
module gpio_srcsel_regs #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] DIR_RST  = '0,
  parameter logic [WIDTH-1:0] DATA_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             dir_wr,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      dir_q  <= DIR_RST;
    end else begin
      if (data_wr) data_q <= wval;
      if (dir_wr)  dir_q  <= wval;
    end
  end

endmodule

// File: rtl/gpio_srcsel_srcctl.sv
module gpio_srcsel_srcctl #(
  parameter int   WIDTH      = 8,
  parameter bit   SHARED_SRC = 1'b0,
  parameter logic SRC_RST    = 1'b0,
  localparam int  SRC_W      = SHARED_SRC ? 1 : WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_wr,
  input  logic [SRC_W-1:0] wval,
  output logic [SRC_W-1:0] src_q,
  output logic [WIDTH-1:0] src_vec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= {SRC_W{SRC_RST}};
    else if (src_wr) src_q <= wval;
  end

  generate
    if (SHARED_SRC) begin : g_shared
      assign src_vec = {WIDTH{src_q[0]}};
    end else begin : g_perpin
      assign src_vec = src_q;
    end
  endgenerate

endmodule

// File: rtl/gpio_srcsel_mux.sv
module gpio_srcsel_mux
  import gpio_srcsel_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] src_vec,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] hw_dir,
  input  logic [WIDTH-1:0] hw_data,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [1:0] pin;
    assign pin        = pick_pin(src_vec[i], dir_q[i], data_q[i], hw_dir[i], hw_data[i]);
    assign pad_oe[i]  = pin[1];
    assign pad_out[i] = pin[0];
  end

endmodule

// File: rtl/gpio_srcsel_port.sv
module gpio_srcsel_port
  import gpio_srcsel_pkg::*;
#(
  parameter int   WIDTH      = 8,
  parameter logic [WIDTH-1:0] DIR_RST  = '0,
  parameter logic [WIDTH-1:0] DATA_RST = '0,
  parameter logic SRC_RST    = 1'b0,
  parameter bit   SHARED_SRC = 1'b0,
  parameter bit   HW_SRC_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [WIDTH-1:0] hw_data,
  input  logic [WIDTH-1:0] hw_dir,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);

  localparam int SRC_W = SHARED_SRC ? 1 : WIDTH;

  reg_sel_e         sel;
  logic             data_wr_hit, dir_wr_hit, src_wr_hit;
  logic [WIDTH-1:0] data_q, dir_q, src_vec;
  logic [SRC_W-1:0] src_q;

  assign sel         = decode_ofs(addr, HW_SRC_EN);
  assign data_wr_hit = wr_en && (sel == SEL_DATA);
  assign dir_wr_hit  = wr_en && (sel == SEL_DIR);
  assign src_wr_hit  = wr_en && (sel == SEL_SRC);

  gpio_srcsel_regs #(
    .WIDTH(WIDTH), .DIR_RST(DIR_RST), .DATA_RST(DATA_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr_hit), .dir_wr(dir_wr_hit),
    .wval(wdata[WIDTH-1:0]), .data_q(data_q), .dir_q(dir_q)
  );

  generate
    if (HW_SRC_EN) begin : g_src
      gpio_srcsel_srcctl #(
        .WIDTH(WIDTH), .SHARED_SRC(SHARED_SRC), .SRC_RST(SRC_RST)
      ) u_src (
        .clk(clk), .rst_n(rst_n), .src_wr(src_wr_hit),
        .wval(wdata[SRC_W-1:0]), .src_q(src_q), .src_vec(src_vec)
      );
    end else begin : g_nosrc
      assign src_q   = '0;
      assign src_vec = '0;
    end
  endgenerate

  gpio_srcsel_mux #(.WIDTH(WIDTH)) u_mux (
    .src_vec(src_vec), .dir_q(dir_q), .data_q(data_q),
    .hw_dir(hw_dir), .hw_data(hw_data), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_DATA: rdata[WIDTH-1:0] = data_q;
      SEL_DIR:  rdata[WIDTH-1:0] = dir_q;
      SEL_SRC:  rdata[SRC_W-1:0] = src_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_srcsel_chk.sv
module gpio_srcsel_chk #(
  parameter int WIDTH      = 8,
  parameter bit SHARED_SRC = 1'b0,
  parameter bit HW_SRC_EN  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [WIDTH-1:0] hw_data,
  input logic [WIDTH-1:0] hw_dir,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] src_vec,
  input logic             data_wr_hit
);

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_hit |=> data_q == $past(wdata[WIDTH-1:0]));

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr_hit |=> $stable(data_q));

  assert_sw_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~src_vec) == '0);

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  assert_hw_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ hw_dir) | (pad_out ^ (hw_data & hw_dir))) & src_vec) == '0);

  assert_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    SHARED_SRC |-> (src_vec == '0 || src_vec == '1));

  assert_no_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !HW_SRC_EN |-> src_vec == '0);

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(rdata) >> WIDTH) == 64'd0);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 8'h0C && addr != 8'h10 && addr != 8'h14) |-> rdata == 32'd0);

endmodule

bind gpio_srcsel_port gpio_srcsel_chk #(
  .WIDTH(WIDTH), .SHARED_SRC(SHARED_SRC), .HW_SRC_EN(HW_SRC_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .hw_data(hw_data), .hw_dir(hw_dir), .pad_oe(pad_oe),
  .pad_out(pad_out), .data_q(data_q), .dir_q(dir_q), .src_vec(src_vec),
  .data_wr_hit(data_wr_hit)
);

// File: tb/test_gpio_srcsel_port.sv
`timescale 1ns/1ps
module test_gpio_srcsel_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [7:0]  hw_data = 8'h00, hw_dir = 8'h00;
  logic [31:0] rd_a, rd_s, rd_n;
  logic [7:0]  oe_a, out_a, oe_s, out_s, oe_n, out_n;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // Per-pin source control
  gpio_srcsel_port #(.WIDTH(8), .DIR_RST(8'h0F), .DATA_RST(8'hA5), .SRC_RST(1'b0),
                     .SHARED_SRC(1'b0), .HW_SRC_EN(1'b1)) i_gpio_srcsel_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rd_a),
    .hw_data(hw_data), .hw_dir(hw_dir), .pad_oe(oe_a), .pad_out(out_a));

  // One shared source bit, reset to hardware
  gpio_srcsel_port #(.WIDTH(8), .DIR_RST(8'h0F), .DATA_RST(8'hA5), .SRC_RST(1'b1),
                     .SHARED_SRC(1'b1), .HW_SRC_EN(1'b1)) i_gpio_srcsel_port_shr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rd_s),
    .hw_data(hw_data), .hw_dir(hw_dir), .pad_oe(oe_s), .pad_out(out_s));

  // Source selection removed
  gpio_srcsel_port #(.WIDTH(8), .DIR_RST(8'h0F), .DATA_RST(8'hA5), .SRC_RST(1'b1),
                     .SHARED_SRC(1'b0), .HW_SRC_EN(1'b0)) i_gpio_srcsel_port_nohw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rd_n),
    .hw_data(hw_data), .hw_dir(hw_dir), .pad_oe(oe_n), .pad_out(out_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    addr = a;
    #2;
  endtask

  task automatic t_reset();
    rd(8'h0C); chk("R1", "data A", rd_a, 32'hA5);
    rd(8'h10); chk("R1", "dir A", rd_a, 32'h0F);
    rd(8'h14); chk("R1", "src A", rd_a, 32'h00);
               chk("R1", "src shared", rd_s, 32'h01);
               chk("R8", "src absent", rd_n, 32'h00);
    chk("R4", "oe A", {24'd0, oe_a}, 32'h0F);
    chk("R4", "out A", {24'd0, out_a}, 32'h05);
    chk("R5", "oe shared hw", {24'd0, oe_s}, 32'hF0);
    chk("R5", "out shared hw", {24'd0, out_s}, 32'h30);
    chk("R8", "out no-hw", {24'd0, out_n}, 32'h05);
  endtask

  task automatic t_data();
    wr(8'h0C, 32'hFFFF_FF3C);
    rd(8'h0C); chk("R2", "data readback", rd_a, 32'h3C);
               chk("R9", "reserved data bits", rd_n, 32'h3C);
    #1 chk("R4", "out after data", {24'd0, out_a}, 32'h0C);
  endtask

  task automatic t_dir();
    wr(8'h10, 32'h0000_00F0);
    rd(8'h10); chk("R3", "dir readback", rd_a, 32'hF0);
    chk("R3", "oe follows dir", {24'd0, oe_a}, 32'hF0);
    chk("R4", "out follows dir", {24'd0, out_a}, 32'h30);
  endtask

  task automatic t_perpin();
    @(negedge clk); hw_dir = 8'h0F; hw_data = 8'h05;
    wr(8'h14, 32'h0000_0005);
    rd(8'h14); chk("R6", "src per-pin", rd_a, 32'h05);
               chk("R7", "src shared bit0", rd_s, 32'h01);
               chk("R8", "src absent after write", rd_n, 32'h00);
    chk("R6", "oe mixed", {24'd0, oe_a}, 32'hF5);
    chk("R5", "out mixed", {24'd0, out_a}, 32'h35);
    chk("R7", "oe shared all hw", {24'd0, oe_s}, 32'h0F);
    chk("R8", "oe no-hw sw", {24'd0, oe_n}, 32'hF0);
    chk("R8", "out no-hw sw", {24'd0, out_n}, 32'h30);
  endtask

  task automatic t_shared();
    wr(8'h14, 32'hFFFF_FFFE);
    rd(8'h14); chk("R9", "src reserved dropped", rd_a, 32'hFE);
               chk("R7", "shared reads bit0 only", rd_s, 32'h00);
    chk("R7", "oe shared all sw", {24'd0, oe_s}, 32'hF0);
    chk("R7", "out shared all sw", {24'd0, out_s}, 32'h30);
    chk("R6", "oe per-pin", {24'd0, oe_a}, 32'h0E);
    chk("R6", "out per-pin", {24'd0, out_a}, 32'h04);
  endtask

  task automatic t_unmapped();
    wr(8'h18, 32'h0000_0012);
    wr(8'h00, 32'h0000_0012);
    wr(8'h0D, 32'h0000_0012);
    rd(8'h18); chk("R10", "read 0x18", rd_a, 32'h0);
    rd(8'h04); chk("R10", "read 0x04", rd_a, 32'h0);
    rd(8'h0C); chk("R10", "data kept", rd_a, 32'h3C);
    rd(8'h10); chk("R10", "dir kept", rd_a, 32'hF0);
    rd(8'h14); chk("R10", "src kept", rd_a, 32'hFE);
    chk("R10", "pads kept", {16'd0, oe_a, out_a}, {16'd0, 8'h0E, 8'h04});
  endtask

  task automatic t_not_pad();
    wr(8'h10, 32'h0);
    rd(8'h0C); chk("R2", "data not pad", rd_n, 32'h3C);
    chk("R3", "all inputs oe", {24'd0, oe_n}, 32'h00);
    chk("R4", "inputs out low", {24'd0, out_n}, 32'h00);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    hw_dir = 8'hF0; hw_data = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data();
    t_dir();
    t_perpin();
    t_shared();
    t_unmapped();
    t_not_pad();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule